// File: doc/BRIEF.md
# GPIO Expander Interrupt Change Detector

This block produces the single interrupt line of a serially controlled general-purpose I/O expander whose pins are grouped in ports of eight. Every port holds a snapshot of the pin levels the host saw when it last read that port. The block compares the synchronized pin levels with that snapshot, masked by the per-pin direction setting. While any pin set as an input differs from its snapshot, the block pulls the interrupt line low.

The interrupt goes away in one of two ways. The pins can return to the snapshot value. The bus engine can also report that the host has read a port's input register: it pulses a per-port strobe at the acknowledge bit of that read, and the strobe reloads that port's snapshot. The serial slave engine and the register file sit outside this block, and only their strobes reach it. The output is a drive-low enable: a 1 pulls the line low, and a 0 releases it to the external pull-up.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is held, `irq_drive_o` is 0. After reset is released with the pins held steady, the snapshots take the first synchronized pin values and `irq_drive_o` stays 0.
- R2: A rising or falling level change on an input pin (direction bit 1) sets `irq_drive_o` at the third rising clock edge after the change. It is still 0 after the second edge.
- R3: A pin whose direction bit is 0 (output) never sets `irq_drive_o`, whatever its level does.
- R4: When every input pin's level returns to its port's snapshot, `irq_drive_o` returns to 0 without any read.
- R5: A read strobe on `rd_ack_i[p]` at a clock edge loads port p's snapshot with the synchronized levels of its pins. If nothing else differs, `irq_drive_o` falls at the following edge.
- R6: A read strobe for one port leaves the snapshot of every other port untouched. An interrupt caused by another port stays asserted.
- R7: Switching a pin from output to input while its level differs from the snapshot sets `irq_drive_o` at the next clock edge.
- R8: A pin change whose synchronized value first appears in the cycle in which a read strobe is sampled is absorbed into the snapshot. It produces at most a one-cycle interrupt pulse and then clears with no further read.
- R9: Without a read strobe, a snapshot holds for any length of time, so bus traffic for other devices cannot clear a pending interrupt.
- R10: `irq_drive_o` equal to 1 means the interrupt line is pulled low. Equal to 0 means the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PORTS*PORT_W | Raw pin levels, port p at bits p*PORT_W upward |
| dir_in_i | input | NUM_PORTS*PORT_W | Per-pin direction, 1 = input, 0 = output |
| rd_ack_i | input | NUM_PORTS | Per-port strobe, high for one cycle at the acknowledge bit of an input-register read |
| irq_drive_o | output | 1 | Open-drain enable, 1 = pull interrupt line low |

## Verification
The assertions take for granted that each read strobe is a single-cycle pulse issued by the bus engine, and that the direction inputs come from a register, so they change only on a clock edge. The bench drives every input on the falling clock edge. It raises a strobe for exactly one cycle, and only after the pins have been steady for at least two cycles, except in the deliberate case of a change that lands in the strobe cycle. Under those conditions, the snapshot the bench keeps for each port matches the value the design should have loaded.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned DEF_NUM_PORTS   = 2;
  localparam int unsigned DEF_PORT_W      = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Number of edges during which snapshots follow the synchronizer after
  // reset: the synchronizer depth plus one edge to capture its output.
  function automatic int unsigned prime_edges(input int unsigned stages);
    return stages + 1;
  endfunction

  // Width of a counter that must reach prime_edges(stages).
  function automatic int unsigned prime_cnt_w(input int unsigned stages);
    return $clog2(stages + 2);
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_prime.sv
module gpio_irq_prime #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic primed_o
);

  import gpio_irq_pkg::*;

  localparam int unsigned CW    = prime_cnt_w(SYNC_STAGES);
  localparam int unsigned LIMIT = prime_edges(SYNC_STAGES);

  logic [CW-1:0] cnt_q;

  assign primed_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!primed_o) cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [PORT_W-1:0] level_i,
  input  logic [PORT_W-1:0] dir_in_i,
  output logic [PORT_W-1:0] snap_o,
  output logic [PORT_W-1:0] pend_o,
  output logic              hit_o
);

  // Pins that count toward the interrupt: input pins whose level has moved
  // away from the snapshot.
  function automatic logic [PORT_W-1:0] pending_bits(
    input logic [PORT_W-1:0] level,
    input logic [PORT_W-1:0] snap,
    input logic [PORT_W-1:0] dir_in
  );
    return (level ^ snap) & dir_in;
  endfunction

  logic [PORT_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (load_i) snap_q <= level_i;
  end

  assign snap_o = snap_q;
  assign pend_o = pending_bits(level_i, snap_q, dir_in_i);
  assign hit_o  = |pend_o;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PORTS   = gpio_irq_pkg::DEF_NUM_PORTS,
  parameter int unsigned PORT_W      = gpio_irq_pkg::DEF_PORT_W,
  parameter int unsigned SYNC_STAGES = gpio_irq_pkg::DEF_SYNC_STAGES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_i,
  input  logic [NUM_PORTS*PORT_W-1:0] dir_in_i,
  input  logic [NUM_PORTS-1:0]        rd_ack_i,
  output logic                        irq_drive_o
);

  localparam int unsigned ALL_W = NUM_PORTS * PORT_W;

  // Named internal events, visible to the bound checker.
  logic [ALL_W-1:0]     sync_lvl;
  logic [ALL_W-1:0]     snap_lvl;
  logic [ALL_W-1:0]     pend_lvl;
  logic [NUM_PORTS-1:0] port_hit;
  logic [NUM_PORTS-1:0] port_load;
  logic                 primed_w;
  logic                 irq_next;
  logic                 irq_q;

  gpio_irq_sync #(
    .W      (ALL_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_i),
    .sync_o (sync_lvl)
  );

  gpio_irq_prime #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_prime (
    .clk      (clk),
    .rst_n    (rst_n),
    .primed_o (primed_w)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      // Snapshots follow the synchronizer until priming ends, then reload
      // only on that port's read strobe.
      assign port_load[p] = rd_ack_i[p] | ~primed_w;

      gpio_irq_port #(
        .PORT_W (PORT_W)
      ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (port_load[p]),
        .level_i  (sync_lvl[p*PORT_W +: PORT_W]),
        .dir_in_i (dir_in_i[p*PORT_W +: PORT_W]),
        .snap_o   (snap_lvl[p*PORT_W +: PORT_W]),
        .pend_o   (pend_lvl[p*PORT_W +: PORT_W]),
        .hit_o    (port_hit[p])
      );
    end
  endgenerate

  assign irq_next = primed_w & (|port_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next;
  end

  assign irq_drive_o = irq_q;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PORT_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_PORTS*PORT_W-1:0] dir_in_i,
  input logic [NUM_PORTS-1:0]        rd_ack_i,
  input logic                        irq_drive_o,
  input logic                        primed_w,
  input logic [NUM_PORTS*PORT_W-1:0] sync_lvl,
  input logic [NUM_PORTS*PORT_W-1:0] snap_lvl
);

  AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_w |=> !irq_drive_o); // R1

  AST_OUTPUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in_i == '0) |=> !irq_drive_o); // R3

  AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == snap_lvl) |=> !irq_drive_o); // R4

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_chk
      AST_ACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_i[p] |=> (snap_lvl[p*PORT_W +: PORT_W] ==
                         $past(sync_lvl[p*PORT_W +: PORT_W]))); // R5

      AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_w && !rd_ack_i[p]) |=> $stable(snap_lvl[p*PORT_W +: PORT_W])); // R9
    end
  endgenerate

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir_in_i    (dir_in_i),
  .rd_ack_i    (rd_ack_i),
  .irq_drive_o (irq_drive_o),
  .primed_w    (primed_w),
  .sync_lvl    (sync_lvl),
  .snap_lvl    (snap_lvl)
);

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;

  localparam int NP = 2;
  localparam int PW = 8;
  localparam int AW = NP * PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] pin_i = '0;
  logic [AW-1:0] dir_in_i = '0;
  logic [NP-1:0] rd_ack_i = '0;
  logic          irq_drive_o;

  logic [AW-1:0] snap_m;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_detect #(
    .NUM_PORTS   (NP),
    .PORT_W      (PW),
    .SYNC_STAGES (2)
  ) u_gpio_irq_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .dir_in_i    (dir_in_i),
    .rd_ack_i    (rd_ack_i),
    .irq_drive_o (irq_drive_o)
  );

  // Settled expectation: any input pin away from the bench's snapshot.
  function automatic logic model_irq();
    return |((pin_i ^ snap_m) & dir_in_i);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    checks++;
    if (irq_drive_o !== exp) begin
      errors++;
      $display("FAIL %s: irq_drive_o got %0b expected %0b", req, irq_drive_o, exp);
    end
  endtask

  // One-cycle read strobe; pins have been steady, so the sync equals pins.
  task automatic read_port(input int p);
    rd_ack_i[p] = 1'b1;
    @(posedge clk);
    snap_m[p*PW +: PW] = pin_i[p*PW +: PW];
    @(negedge clk);
    rd_ack_i = '0;
  endtask

  initial begin
    #160000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_i    = 16'h5AA5;
    dir_in_i = '1;
    snap_m   = 16'h5AA5;
    tick(3);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    tick(1);
    check(1'b0, "R1 priming");
    tick(6);
    check(1'b0, "R1 after priming");

    for (int p = 0; p < NP; p++) begin
      for (int b = 0; b < PW; b++) begin
        logic [AW-1:0] m;
        m = AW'(1) << (p*PW + b);
        // R2 latency, either edge direction depending on the pattern bit
        pin_i ^= m;
        tick(2);
        check(1'b0, "R2 not yet after two edges");
        tick(1);
        check(1'b1, "R2 R10 raised on third edge");
        // R4 return to snapshot
        pin_i ^= m;
        tick(4);
        check(model_irq(), "R4 back to snapshot");
        // R3 output pin toggles silently
        dir_in_i &= ~m;
        pin_i ^= m;
        tick(4);
        check(1'b0, "R3 output pin ignored");
        // R7 switch to input with mismatch
        dir_in_i |= m;
        tick(1);
        check(1'b1, "R7 output to input mismatch");
        // R5 read clears
        read_port(p);
        check(1'b1, "R5 still set at strobe edge");
        tick(1);
        check(model_irq(), "R5 cleared after read");
        // opposite edge relative to new snapshot
        pin_i ^= m;
        tick(4);
        check(model_irq(), "R2 opposite edge");
        // R6 read of the other port does not clear
        read_port(1 - p);
        tick(2);
        check(1'b1, "R6 other port read");
        // R9 hold without strobe
        tick(40);
        check(1'b1, "R9 holds without read");
        read_port(p);
        tick(1);
        check(1'b0, "R5 second read clears");
      end
    end

    // R8 change landing in the strobe cycle
    pin_i ^= 16'h0001;
    tick(2);
    rd_ack_i[0] = 1'b1;
    tick(1);
    rd_ack_i = '0;
    snap_m = pin_i;
    check(1'b1, "R8 short pulse");
    tick(1);
    check(1'b0, "R8 absorbed into snapshot");
    tick(5);
    check(model_irq(), "R8 stays clear");

    // R3 all outputs with busy pins
    dir_in_i = '0;
    for (int k = 0; k < 8; k++) begin
      pin_i = pin_i + 16'h1357;
      tick(3);
      check(1'b0, "R3 all outputs");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule